// File: doc/BRIEF.md
# Alarm Interconnect Line Controller

This block looks after the single wired line that ties a group of alarm units together. While the local unit is alarming, the block drives the line high so that every other unit on the line also alarms. In the other direction it watches the sampled line level and reports a remote alarm only once the line has stayed high for a set number of base clocks. Short pulses from other kinds of alarm on the same wire are therefore not taken as an alarm.

The block also tells the two roles apart. A unit that alarms from its own sensor is the signalling unit and keeps flashing its LED. A unit that alarms only because of the line gets an LED inhibit. When the local alarm ends, a discharge sink on the line is switched on for exactly one slow-clock period, measured from one slow tick to the next. The line drive and the sink are never on together.

Top module: `alarm_link_ctrl`

## Requirements
- R1: `drive_en` equals the value of `local_alarm` sampled at the previous rising clock edge.
- R2: `remote_alarm` goes high after `FILT_CYCLES` consecutive rising edges at which `line_in` is 1, while neither `local_alarm` nor `drive_en` is 1. It is high right after the `FILT_CYCLES`-th such edge and not before.
- R3: A single edge that samples `line_in` at 0 restarts the persistence count, and also clears `remote_alarm` right after that edge.
- R4: The unit ignores its own drive. At any edge where `local_alarm` or `drive_en` is 1, the count restarts and `remote_alarm` is 0 after that edge, whatever `line_in` is.
- R5: `led_inhibit` is the registered value of (`remote_alarm` and not `local_alarm`), so it follows `remote_alarm` one cycle later. A unit in local alarm never has the inhibit.
- R6: After the local alarm ends, `sink_en` rises right after the first edge that samples `slow_tick` at 1. It falls right after the next such edge, so it stays high for exactly one slow-clock period.
- R7: `drive_en` and `sink_en` are never high together. When `local_alarm` returns, any pending or active sink is cancelled at the same edge.
- R8: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle pulse once per slow-clock period |
| local_alarm | input | 1 | Local sensor alarm condition |
| line_in | input | 1 | Sampled level of the interconnect line |
| drive_en | output | 1 | Drive the interconnect line high |
| sink_en | output | 1 | Enable the line discharge sink |
| remote_alarm | output | 1 | Filtered alarm received from the line |
| led_inhibit | output | 1 | Suppress local LED flash (alarm from line only) |

## Verification
Each output has a fixed delay. `drive_en` and the sink edges show up one edge after the `local_alarm` or `slow_tick` sample that causes them. `remote_alarm` shows up at the `FILT_CYCLES`-th consecutive high sample, and `led_inhibit` one edge later. The bench changes inputs on falling edges and reads outputs on the next falling edge, after the counted number of rising edges. For the filter it checks one sample before the due edge and one sample at it. For the sink it checks every cycle between the two slow ticks, so that both the length and the placement of the pulse are confirmed.

// File: rtl/alarm_link_pkg.sv
package alarm_link_pkg;

    typedef enum logic [1:0] {
        DUMP_IDLE = 2'd0,
        DUMP_ARM  = 2'd1,
        DUMP_ON   = 2'd2
    } dump_st_e;

    typedef struct packed {
        dump_st_e st;
        logic     sink;
    } dump_reg_s;

    typedef struct packed {
        logic drive;
        logic inhibit;
    } role_reg_s;

endpackage

// File: rtl/link_filter.sv
module link_filter #(
    parameter int FILT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic block,
    output logic remote
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hit;
    } filt_reg_s;

    filt_reg_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (block || !line_in) begin
            nxt_d.cnt = '0;
            nxt_d.hit = 1'b0;
        end else if (!cur_q.hit) begin
            if (cur_q.cnt == LAST) begin
                nxt_d.hit = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign remote = cur_q.hit;
endmodule

// File: rtl/dump_pulse.sv
module dump_pulse
    import alarm_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic local_alarm,
    input  logic drive_q,
    input  logic slow_tick,
    output logic sink
);
    dump_reg_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (local_alarm) begin
            nxt_d.st = DUMP_IDLE;
        end else begin
            unique case (cur_q.st)
                DUMP_IDLE: if (drive_q)   nxt_d.st = DUMP_ARM;
                DUMP_ARM:  if (slow_tick) nxt_d.st = DUMP_ON;
                DUMP_ON:   if (slow_tick) nxt_d.st = DUMP_IDLE;
                default:                  nxt_d.st = DUMP_IDLE;
            endcase
        end
        nxt_d.sink = (nxt_d.st == DUMP_ON);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: DUMP_IDLE, sink: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sink = cur_q.sink;
endmodule

// File: rtl/role_ctrl.sv
module role_ctrl
    import alarm_link_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic local_alarm,
    input  logic remote,
    output logic drive,
    output logic inhibit
);
    role_reg_s cur_q, nxt_d;

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.drive   = local_alarm;
        nxt_d.inhibit = remote && !local_alarm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign drive   = cur_q.drive;
    assign inhibit = cur_q.inhibit;
endmodule

// File: rtl/alarm_link_ctrl.sv
module alarm_link_ctrl #(
    parameter int FILT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    input  logic local_alarm,
    input  logic line_in,
    output logic drive_en,
    output logic sink_en,
    output logic remote_alarm,
    output logic led_inhibit
);
    logic drive_w;
    logic remote_w;
    logic block_w;

    // own drive masks the line input
    assign block_w = local_alarm || drive_w;

    link_filter #(
        .FILT_CYCLES(FILT_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .block  (block_w),
        .remote (remote_w)
    );

    role_ctrl u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_alarm(local_alarm),
        .remote     (remote_w),
        .drive      (drive_w),
        .inhibit    (led_inhibit)
    );

    dump_pulse u_dump (
        .clk        (clk),
        .rst_n      (rst_n),
        .local_alarm(local_alarm),
        .drive_q    (drive_w),
        .slow_tick  (slow_tick),
        .sink       (sink_en)
    );

    assign drive_en     = drive_w;
    assign remote_alarm = remote_w;
endmodule

// File: rtl/alarm_link_ctrl_chk.sv
module alarm_link_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic slow_tick,
    input logic local_alarm,
    input logic line_in,
    input logic drive_en,
    input logic sink_en,
    input logic remote_alarm,
    input logic led_inhibit
);
    AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        local_alarm |=> drive_en); // R1
    AST_REMOTE_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote_alarm) |-> ($past(line_in) && !$past(local_alarm))); // R2
    AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_in |=> !remote_alarm); // R3
    AST_OWN_DRIVE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> !remote_alarm); // R4
    AST_INHIBIT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        led_inhibit |-> ($past(remote_alarm) && !drive_en)); // R5
    AST_SINK_RISE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_en) |-> $past(slow_tick)); // R6
    AST_SINK_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sink_en) |-> ($past(slow_tick) || $past(local_alarm))); // R6
    AST_NO_DRIVE_AND_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_en && sink_en)); // R7
endmodule

bind alarm_link_ctrl alarm_link_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_tick   (slow_tick),
    .local_alarm (local_alarm),
    .line_in     (line_in),
    .drive_en    (drive_en),
    .sink_en     (sink_en),
    .remote_alarm(remote_alarm),
    .led_inhibit (led_inhibit)
);

// File: tb/test_alarm_link_ctrl.sv
`timescale 1ns/1ps
module test_alarm_link_ctrl;
    localparam int FILT = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slow_tick = 1'b0;
    logic local_alarm = 1'b0;
    logic line_in = 1'b0;
    logic drive_en, sink_en, remote_alarm, led_inhibit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alarm_link_ctrl #(.FILT_CYCLES(FILT)) i_alarm_link_ctrl (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
        .local_alarm(local_alarm), .line_in(line_in),
        .drive_en(drive_en), .sink_en(sink_en),
        .remote_alarm(remote_alarm), .led_inhibit(led_inhibit)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8", "drive_en in reset", drive_en, 1'b0);
        check("R8", "sink_en in reset", sink_en, 1'b0);
        check("R8", "remote_alarm in reset", remote_alarm, 1'b0);
        check("R8", "led_inhibit in reset", led_inhibit, 1'b0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_filter();
        line_in = 1'b1;
        step(FILT - 1);
        check("R2", "remote one sample early", remote_alarm, 1'b0);
        step(1);
        check("R2", "remote at filter length", remote_alarm, 1'b1);
        check("R5", "inhibit lags remote", led_inhibit, 1'b0);
        step(1);
        check("R5", "inhibit on slave unit", led_inhibit, 1'b1);
        line_in = 1'b0;
        step(1);
        check("R3", "low sample clears remote", remote_alarm, 1'b0);
        step(1);
        check("R5", "inhibit follows clear", led_inhibit, 1'b0);
    endtask

    task automatic t_glitch();
        line_in = 1'b1;
        step(FILT - 1);
        line_in = 1'b0;
        step(1);
        line_in = 1'b1;
        step(FILT - 1);
        check("R3", "count restarted after glitch", remote_alarm, 1'b0);
        step(1);
        check("R3", "full run after glitch", remote_alarm, 1'b1);
    endtask

    task automatic t_signalling();
        // remote currently high; local alarm takes over
        local_alarm = 1'b1;
        step(1);
        check("R1", "drive follows local", drive_en, 1'b1);
        check("R4", "remote dropped by own alarm", remote_alarm, 1'b0);
        check("R5", "no inhibit on signalling unit", led_inhibit, 1'b0);
        step(2 * FILT);
        check("R4", "own drive not seen as remote", remote_alarm, 1'b0);
        check("R7", "no sink while driving", sink_en, 1'b0);
        local_alarm = 1'b0;
        line_in = 1'b0;
        step(1);
        check("R1", "drive released", drive_en, 1'b0);
        check("R6", "sink waits for tick", sink_en, 1'b0);
    endtask

    task automatic pulse_tick();
        slow_tick = 1'b1;
        step(1);
        slow_tick = 1'b0;
    endtask

    task automatic t_sink();
        step(5);
        check("R6", "sink idle before tick", sink_en, 1'b0);
        pulse_tick();
        check("R6", "sink on after first tick", sink_en, 1'b1);
        for (int i = 0; i < 30; i++) begin
            step(1);
            check("R6", "sink held for period", sink_en, 1'b1);
        end
        pulse_tick();
        check("R6", "sink off after second tick", sink_en, 1'b0);
        step(3);
        pulse_tick();
        check("R6", "no repeat pulse", sink_en, 1'b0);
    endtask

    task automatic t_cancel();
        local_alarm = 1'b1;
        step(3);
        local_alarm = 1'b0;
        step(2);
        pulse_tick();
        check("R6", "sink on for cancel test", sink_en, 1'b1);
        local_alarm = 1'b1;
        step(1);
        check("R7", "sink cancelled by alarm", sink_en, 1'b0);
        check("R7", "drive back on", drive_en, 1'b1);
        local_alarm = 1'b0;
        step(1);
        pulse_tick();
        pulse_tick();
        check("R6", "new dump ends", sink_en, 1'b0);
    endtask

    initial begin
        step(3);
        t_reset();
        t_filter();
        t_glitch();
        t_signalling();
        t_sink();
        t_cancel();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule